// File: doc/BRIEF.md
# Fixed-Priority DMA Request Arbiter

This block decides which of 23 peripheral DMA channels may use the single 32-bit internal data path to memory in a given cycle. Every channel raises one request line and watches one grant line. Channels are organised into four peripheral groups: serial ports, parallel port, input data port and SPI. Each group has its own enable bit. On every clock edge the arbiter registers a one-hot grant to the lowest-numbered channel that is requesting and enabled. One cycle after the grant, a bus stage puts that channel's word on the shared bus, either towards memory or from it.

A channel keeps its request high until it sees its grant. During the grant cycle it either drops the request or leaves it high when it has another word waiting. The channel that holds the grant is left out of the arbitration that takes place in the same cycle. Because of this, a request that is still high during the grant cycle is not counted twice. Memory is modelled as a plain port: a write strobe with data going out, and read data coming in.

Top module: `dma_prio_arb`

## Requirements
- R1: While rst_ni is low, gnt_o is all zero, xfer_vld_o and mem_we_o are 0 and bus_o is zero.
- R2: gnt_o has at most one bit set. It is non-zero in a cycle exactly when at least one channel was eligible at the previous clock edge.
- R3: A channel is eligible when its req_i bit is 1, its group enable is 1 and its own gnt_o bit is 0. The registered grant goes to the eligible channel with the lowest index, because index 0 has the highest priority.
- R4: A channel whose group enable bit is 0 never receives a grant, whatever its request does.
- R5: Groups map to channels and to grp_en_i bits as follows. Bit 0 enables serial ports, channels 0 to 11. Bit 1 enables the parallel port, channel 12. Bit 2 enables the input data port, channels 13 to 20. Bit 3 enables SPI, channels 21 and 22.
- R6: The channel granted in one cycle cannot be granted in the next cycle, even if its request is still high. It can be granted again at the earliest two cycles after its previous grant.
- R7: In the cycle after any grant, xfer_vld_o is 1 and xfer_ch_o holds the granted index. xfer_wr_o holds that channel's dir_i bit as sampled at the arbitration edge. xfer_vld_o is 0 after a cycle with no grant.
- R8: In a transfer cycle with xfer_wr_o = 1 (peripheral to memory), mem_we_o is 1 and bus_o equals the 32-bit slice of per_wdata_i at position xfer_ch_o.
- R9: In a transfer cycle with xfer_wr_o = 0 (memory to peripheral), mem_we_o is 0 and bus_o equals mem_rdata_i. When no transfer is running, bus_o is zero and mem_we_o is 0.
- R10: If a higher-priority request rises in the cycle in which a lower-priority grant is shown, that grant still moves its word in the next cycle. The higher-priority channel is granted at the next arbitration edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 23 | Per-channel DMA request |
| dir_i | input | 23 | Per-channel direction, 1 = peripheral to memory |
| grp_en_i | input | 4 | Group DMA enables (serial, parallel, input data, SPI) |
| per_wdata_i | input | 736 | Per-channel outgoing words, channel c at bits 32c+31:32c |
| mem_rdata_i | input | 32 | Word read from memory |
| gnt_o | output | 23 | Registered one-hot grant |
| xfer_vld_o | output | 1 | Transfer on bus this cycle |
| xfer_ch_o | output | 5 | Channel index of current transfer |
| xfer_wr_o | output | 1 | Direction of current transfer |
| mem_we_o | output | 1 | Memory write strobe |
| bus_o | output | 32 | Shared 32-bit data bus |

## Verification
The assertions check the following on every cycle: the grant is one-hot, it only goes to a channel that was requesting and enabled, no lower-priority grant is given while a higher-priority channel is eligible, the holding channel is never granted twice in a row, and the grant is followed by its transfer with the correct index and bus contents. Some behaviours only the bench scenarios can show. These are that the group-to-channel map matches R5, that a late higher-priority request waits exactly one arbitration cycle, and that channels which keep requesting through saturation are served in the interleaving expected from R3 and R6.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  typedef enum logic [1:0] {
    GRP_SER = 2'd0,
    GRP_PAR = 2'd1,
    GRP_IDP = 2'd2,
    GRP_SPI = 2'd3
  } grp_e;

  localparam int unsigned NUM_GRP = 4;

  // Channel-to-group map; groups occupy contiguous index ranges in priority order
  function automatic grp_e grp_of(int unsigned ch, int unsigned n_ser,
                                  int unsigned n_par, int unsigned n_idp);
    if (ch < n_ser)               return GRP_SER;
    if (ch < n_ser + n_par)       return GRP_PAR;
    if (ch < n_ser + n_par + n_idp) return GRP_IDP;
    return GRP_SPI;
  endfunction

endpackage

// File: rtl/dma_grp_gate.sv
module dma_grp_gate
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_SER = 12,
  parameter int unsigned N_PAR = 1,
  parameter int unsigned N_IDP = 8,
  parameter int unsigned N_SPI = 2,
  localparam int unsigned N_CH = N_SER + N_PAR + N_IDP + N_SPI
) (
  input  logic [N_CH-1:0]    req_i,
  input  logic [NUM_GRP-1:0] grp_en_i,
  input  logic [N_CH-1:0]    hold_i,
  output logic [N_CH-1:0]    elig_o
);

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    localparam int unsigned GIDX = int'(grp_of(c, N_SER, N_PAR, N_IDP));
    // holding channel sits out one round so a lingering request is not recounted
    assign elig_o[c] = req_i[c] & grp_en_i[GIDX] & ~hold_i[c];
  end

endmodule

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned N_CH = 23,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic [N_CH-1:0] elig_i,
  output logic [N_CH-1:0] win_o,
  output logic [CH_W-1:0] win_idx_o,
  output logic            any_o
);

  always_comb begin
    win_o     = '0;
    win_idx_o = '0;
    for (int i = N_CH - 1; i >= 0; i--) begin
      if (elig_i[i]) begin
        win_o     = '0;
        win_o[i]  = 1'b1;
        win_idx_o = CH_W'(i);
      end
    end
    any_o = |elig_i;
  end

endmodule

// File: rtl/dma_bus_stage.sv
module dma_bus_stage #(
  parameter int unsigned N_CH   = 23,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   gnt_vld_i,
  input  logic [CH_W-1:0]        gnt_idx_i,
  input  logic                   gnt_wr_i,
  input  logic [N_CH*DATA_W-1:0] per_wdata_i,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic                   xfer_vld_o,
  output logic [CH_W-1:0]        xfer_ch_o,
  output logic                   xfer_wr_o,
  output logic                   mem_we_o,
  output logic [DATA_W-1:0]      bus_o
);

  logic            vld_q;
  logic [CH_W-1:0] ch_q;
  logic            wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= 1'b0;
      ch_q  <= '0;
      wr_q  <= 1'b0;
    end else begin
      vld_q <= gnt_vld_i;
      if (gnt_vld_i) begin
        ch_q <= gnt_idx_i;
        wr_q <= gnt_wr_i;
      end
    end
  end

  always_comb begin
    bus_o = '0;
    if (vld_q) begin
      if (wr_q) bus_o = per_wdata_i[int'(ch_q)*DATA_W +: DATA_W];
      else      bus_o = mem_rdata_i;
    end
  end

  assign xfer_vld_o = vld_q;
  assign xfer_ch_o  = ch_q;
  assign xfer_wr_o  = wr_q;
  assign mem_we_o   = vld_q & wr_q;

endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_SER  = 12,
  parameter int unsigned N_PAR  = 1,
  parameter int unsigned N_IDP  = 8,
  parameter int unsigned N_SPI  = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N_CH  = N_SER + N_PAR + N_IDP + N_SPI,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_CH-1:0]        req_i,
  input  logic [N_CH-1:0]        dir_i,
  input  logic [NUM_GRP-1:0]     grp_en_i,
  input  logic [N_CH*DATA_W-1:0] per_wdata_i,
  input  logic [DATA_W-1:0]      mem_rdata_i,
  output logic [N_CH-1:0]        gnt_o,
  output logic                   xfer_vld_o,
  output logic [CH_W-1:0]        xfer_ch_o,
  output logic                   xfer_wr_o,
  output logic                   mem_we_o,
  output logic [DATA_W-1:0]      bus_o
);

  logic [N_CH-1:0] elig;
  logic [N_CH-1:0] win;
  logic [CH_W-1:0] win_idx;
  logic            win_any;

  logic [N_CH-1:0] gnt_q;
  logic [CH_W-1:0] gnt_idx_q;
  logic            gnt_wr_q;

  dma_grp_gate #(
    .N_SER(N_SER), .N_PAR(N_PAR), .N_IDP(N_IDP), .N_SPI(N_SPI)
  ) i_gate (
    .req_i    (req_i),
    .grp_en_i (grp_en_i),
    .hold_i   (gnt_q),
    .elig_o   (elig)
  );

  dma_prio_pick #(.N_CH(N_CH)) i_pick (
    .elig_i    (elig),
    .win_o     (win),
    .win_idx_o (win_idx),
    .any_o     (win_any)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gnt_q     <= '0;
      gnt_idx_q <= '0;
      gnt_wr_q  <= 1'b0;
    end else begin
      gnt_q <= win;
      if (win_any) begin
        gnt_idx_q <= win_idx;
        gnt_wr_q  <= dir_i[win_idx];
      end
    end
  end

  dma_bus_stage #(.N_CH(N_CH), .DATA_W(DATA_W)) i_bus (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_vld_i   (|gnt_q),
    .gnt_idx_i   (gnt_idx_q),
    .gnt_wr_i    (gnt_wr_q),
    .per_wdata_i (per_wdata_i),
    .mem_rdata_i (mem_rdata_i),
    .xfer_vld_o  (xfer_vld_o),
    .xfer_ch_o   (xfer_ch_o),
    .xfer_wr_o   (xfer_wr_o),
    .mem_we_o    (mem_we_o),
    .bus_o       (bus_o)
  );

  assign gnt_o = gnt_q;

endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk
  import dma_arb_pkg::*;
#(
  parameter int unsigned N_SER  = 12,
  parameter int unsigned N_PAR  = 1,
  parameter int unsigned N_IDP  = 8,
  parameter int unsigned N_SPI  = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned N_CH  = N_SER + N_PAR + N_IDP + N_SPI,
  localparam int unsigned CH_W  = $clog2(N_CH)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_CH-1:0]        req_i,
  input logic [N_CH-1:0]        dir_i,
  input logic [NUM_GRP-1:0]     grp_en_i,
  input logic [N_CH*DATA_W-1:0] per_wdata_i,
  input logic [DATA_W-1:0]      mem_rdata_i,
  input logic [N_CH-1:0]        gnt_o,
  input logic                   xfer_vld_o,
  input logic [CH_W-1:0]        xfer_ch_o,
  input logic                   xfer_wr_o,
  input logic                   mem_we_o,
  input logic [DATA_W-1:0]      bus_o
);

  logic [N_CH-1:0] en_mask;
  logic [N_CH-1:0] elig_m;
  logic [N_CH-1:0] low_m;
  logic [CH_W-1:0] gnt_idx_m;
  logic            gnt_dir_m;

  always_comb begin
    for (int c = 0; c < N_CH; c++)
      en_mask[c] = grp_en_i[int'(grp_of(c, N_SER, N_PAR, N_IDP))];
    elig_m = req_i & en_mask & ~gnt_o;
    low_m  = elig_m & (~elig_m + 1'b1);
    gnt_idx_m = '0;
    for (int c = 0; c < N_CH; c++)
      if (gnt_o[c]) gnt_idx_m = CH_W'(c);
  end

  assign gnt_dir_m = |(low_m & dir_i);

  p_rst_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (gnt_o == '0 && !xfer_vld_o && !mem_we_o));

  p_gnt_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  p_gnt_when_elig_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_m != '0) |=> (gnt_o != '0));

  p_no_gnt_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_m == '0) |=> (gnt_o == '0));

  p_gnt_prio_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_m != '0) |=> (gnt_o == $past(low_m)));

  p_dis_no_gnt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |=> ((gnt_o & ~$past(en_mask)) == '0));

  p_no_back2back_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |=> ((gnt_o & $past(gnt_o)) == '0));

  p_xfer_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o != '0) |=> (xfer_vld_o && xfer_ch_o == $past(gnt_idx_m)));

  p_xfer_dir_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (elig_m != '0) |=> ##1 (xfer_wr_o == $past(gnt_dir_m, 2)));

  p_xfer_idle_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o == '0) |=> !xfer_vld_o);

  p_wr_bus_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_vld_o && xfer_wr_o) |->
      (mem_we_o && bus_o == per_wdata_i[int'(xfer_ch_o)*DATA_W +: DATA_W]));

  p_rd_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xfer_vld_o && !xfer_wr_o) |-> (!mem_we_o && bus_o == mem_rdata_i));

  p_idle_bus_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_vld_o |-> (!mem_we_o && bus_o == '0));

endmodule

bind dma_prio_arb dma_prio_arb_chk #(
  .N_SER(N_SER), .N_PAR(N_PAR), .N_IDP(N_IDP), .N_SPI(N_SPI), .DATA_W(DATA_W)
) i_chk (.*);

// File: tb/test_dma_prio_arb.sv
`timescale 1ns/1ps
module test_dma_prio_arb;

  localparam int NC = 23;
  localparam int DW = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic [NC-1:0]     req_i = '0;
  logic [NC-1:0]     dir_i = '0;
  logic [3:0]        grp_en_i = '0;
  logic [NC*DW-1:0]  per_wdata_i = '0;
  logic [DW-1:0]     mem_rdata_i = '0;
  logic [NC-1:0]     gnt_o;
  logic              xfer_vld_o;
  logic [4:0]        xfer_ch_o;
  logic              xfer_wr_o;
  logic              mem_we_o;
  logic [DW-1:0]     bus_o;

  always #10 clk_i = ~clk_i;

  dma_prio_arb i_dma_prio_arb (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [NC-1:0] a_req = '0, a_dir = '0, e_gnt = '0;
  logic [3:0]    a_en = '0;
  string         a_tag = "R3";
  logic          e_dir = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [NC-1:0] en_of(input logic [3:0] en);
    logic [NC-1:0] m;
    for (int c = 0; c < NC; c++) begin
      if (c < 12)      m[c] = en[0];
      else if (c < 13) m[c] = en[1];
      else if (c < 21) m[c] = en[2];
      else             m[c] = en[3];
    end
    return m;
  endfunction

  function automatic int idx_of(input logic [NC-1:0] v);
    for (int c = 0; c < NC; c++) if (v[c]) return c;
    return 0;
  endfunction

  function automatic logic [NC-1:0] first_of(input logic [NC-1:0] v);
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++) if (v[c]) begin r[c] = 1'b1; return r; end
    return r;
  endfunction

  task automatic step(input logic [NC-1:0] req, input logic [3:0] en,
                      input logic [NC-1:0] dir, input string tag);
    logic [NC-1:0] nxt;
    logic          e_vld, e_wr;
    int            e_ch;
    logic [DW-1:0] e_bus;
    @(negedge clk_i);
    nxt   = first_of(a_req & en_of(a_en) & ~e_gnt);
    e_vld = (e_gnt != '0);
    e_ch  = idx_of(e_gnt);
    e_wr  = e_dir;
    if (nxt != '0) e_dir = a_dir[idx_of(nxt)];
    e_gnt = nxt;
    chk({a_tag, " gnt"}, 64'(gnt_o), 64'(e_gnt));
    chk("R7 xfer_vld", 64'(xfer_vld_o), 64'(e_vld));
    if (e_vld) begin
      chk("R7 xfer_ch", 64'(xfer_ch_o), 64'(e_ch));
      chk("R7 xfer_wr", 64'(xfer_wr_o), 64'(e_wr));
    end
    req_i = req; grp_en_i = en; dir_i = dir;
    for (int c = 0; c < NC; c++) per_wdata_i[c*DW +: DW] = $urandom;
    mem_rdata_i = $urandom;
    a_req = req; a_en = en; a_dir = dir; a_tag = tag;
    #1;
    e_bus = !e_vld ? '0 : (e_wr ? per_wdata_i[e_ch*DW +: DW] : mem_rdata_i);
    chk(e_wr ? "R8 bus" : "R9 bus", 64'(bus_o), 64'(e_bus));
    chk(e_wr ? "R8 we" : "R9 we", 64'(mem_we_o), 64'(e_vld & e_wr));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [NC-1:0] all1;
    all1 = '1;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk_i);
    req_i = all1; grp_en_i = '1; dir_i = all1;
    #1;
    // R1 reset state with requests pending
    chk("R1 gnt", 64'(gnt_o), 64'd0);
    chk("R1 xfer_vld", 64'(xfer_vld_o), 64'd0);
    chk("R1 we", 64'(mem_we_o), 64'd0);
    chk("R1 bus", 64'(bus_o), 64'd0);
    @(negedge clk_i);
    req_i = '0; grp_en_i = '0; dir_i = '0;
    rst_ni = 1'b1;

    // R6 saturation: channel 0 and 1 alternate
    repeat (6) step(all1, 4'hf, all1, "R6");
    // R4 serial group off, then everything off
    repeat (4) step(all1, 4'b1110, '0, "R4");
    repeat (3) step(all1, 4'b0000, all1, "R4");
    step('0, 4'hf, '0, "R2");
    // R5 group map edges
    repeat (3) step(all1, 4'b0100, all1, "R5");
    repeat (3) step(all1, 4'b1000, '0, "R5");
    repeat (3) step(all1, 4'b0010, all1, "R5");
    step('0, 4'hf, '0, "R2");
    // R10 late higher-priority request
    step(23'h40_0000, 4'hf, all1, "R10");
    step(23'h40_0001, 4'hf, '0, "R10");
    step(23'h40_0001, 4'hf, '0, "R10");
    step('0, 4'hf, '0, "R10");
    step('0, 4'hf, '0, "R2");
    // R8 / R9 directions over a spread of channels
    step(23'h00_1000, 4'hf, all1, "R8");
    step(23'h10_0000, 4'hf, '0, "R9");
    step('0, 4'hf, '0, "R9");
    // random traffic
    for (int k = 0; k < 4000; k++) begin
      logic [NC-1:0] r, d;
      logic [3:0] en;
      int dens;
      dens = (k / 500) % 4;
      r = NC'($urandom);
      for (int j = 0; j < dens; j++) r &= NC'($urandom);
      d = NC'($urandom);
      en = ($urandom % 4 == 0) ? 4'($urandom) : 4'hf;
      step(r, en, d, "R3");
    end
    step('0, 4'hf, '0, "R2");
    step('0, 4'hf, '0, "R2");
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule